// File: doc/BRIEF.md
# SMBus Byte-Protocol Register Slave

This block sits between a two-wire SMBus segment and a register file. It watches oversampled SCL and SDA, recognises only the single-byte write transaction and the single-byte read transaction (the read uses a repeated START), and pulls SDA low through an open-drain enable to acknowledge bytes and to send read data. The register file is reached through a plain bus. The bus carries the latched register index, the data byte, a one-cycle write strobe, the read data, and a flag that says whether the index names a real register.

Anything outside those two frames is dropped without an acknowledge and leaves every register untouched. This covers a foreign address, the general call, a read with no preceding index, a frame missing its STOP, and a frame with extra bytes. The block also answers the alert response address while an alert is pending, returns its own address as the reply, and then pulses a clear toward the alert source. If SCL is held low for too long, the block drops the partial frame and frees the bus.

Top module: `smb_regslave`

## Requirements
- R1: The device address is `BASE_ADDR | {5'b0, strap_sel}` when `strap_en` is 1 and `FIXED_ADDR` when it is 0; defaults are 7'h2C and 7'h2E. An address byte carrying this address with R/W bit 0 is acknowledged. Any other address that no other requirement accepts is not acknowledged, and the slave stays silent until the next START.
- R2: After a fully acknowledged device-address, index and data sequence, the slave waits for STOP. At STOP it raises `reg_we` for exactly one clock, with `reg_addr` holding the index and `reg_wdata` the data, provided `reg_defined` is 1.
- R3: A write frame ended by a START instead of STOP causes no `reg_we`. So does a write frame in which the master clocks a further byte after the data byte. That further byte is not acknowledged.
- R4: For a read, the device address is sent with R/W bit 1 after a repeated START that follows an acknowledged index. The slave acknowledges it and sends `reg_rdata` MSB first, or 8'h00 when `reg_defined` is 0.
- R5: A device address with R/W bit 1 directly after a plain START (no index phase) is not acknowledged. After the one read byte, the slave leaves SDA released even if the master acknowledges, so a further byte reads 8'hFF.
- R6: A write to an index with `reg_defined` 0 has all three bytes acknowledged but produces no `reg_we`.
- R7: The general call address 7'b0000000 is never acknowledged.
- R8: The byte 8'h19 (address 7'b0001100, R/W 1) is acknowledged only while `alert_pend` is 1. The reply byte is `{device address, 1'b0}`. After the master's acknowledge bit for that byte, `alert_clr` pulses for one clock.
- R9: When a frame is in progress and the synchronised SCL stays low for more than `TIMEOUT_CYC` clocks, SDA is released and the slave returns to idle. A following valid frame is then served normally.
- R10: `sda_oe` = 1 pulls SDA low. It becomes 1 only while the synchronised SCL is low.
- R11: During and right after reset, `sda_oe`, `reg_we` and `alert_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_en | input | 1 | Selects strapped address (1) or fixed address (0) |
| strap_sel | input | 2 | Low address bits when strapped |
| reg_addr | output | 8 | Register index from the last index byte |
| reg_wdata | output | 8 | Data byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Data of register `reg_addr` |
| reg_defined | input | 1 | `reg_addr` names an existing register |
| alert_pend | input | 1 | An alert toward the host is pending |
| alert_clr | output | 1 | One-cycle pulse after the alert reply is sent |

## Verification
Some properties are checked on every cycle by the assertions. SDA is only ever grabbed while the synchronised SCL is low. The write strobe and the alert clear are single-cycle pulses, and the clear only appears while an alert is pending. A long SCL-low spell always ends with SDA released. Only the bench scenarios can show the frame-level behaviour. These are: which address bytes are acknowledged, read data and the zero reply for missing registers, no commit for a missing STOP or an extra byte, the lone read byte, and the alert reply contents. The bench drives whole frames from a bit-level master and compares against its own register model.

// File: rtl/smb_regslave.sv
module smb_regslave #(
  parameter logic [6:0]  FIXED_ADDR  = 7'h2E,
  parameter logic [6:0]  BASE_ADDR   = 7'h2C,
  parameter int unsigned TIMEOUT_CYC = 750000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic       strap_en,
  input  logic [1:0] strap_sel,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata,
  input  logic       reg_defined,
  input  logic       alert_pend,
  output logic       alert_clr
);
  localparam logic [6:0] ALERT_ADDR = 7'b0001100;
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ACK, S_REGA, S_DATA, S_STOPW, S_TX, S_TXACK, S_IGN
  } state_t;

  state_t state, nxt;
  logic [2:0] scl_sr, sda_sr;
  logic [3:0] bcnt;
  logic [7:0] sh, txsh;
  logic       rs_ok, ara;
  logic [TW-1:0] tcnt;

  logic scl_s, scl_q, sda_s, sda_q;
  assign scl_s = scl_sr[1];
  assign scl_q = scl_sr[2];
  assign sda_s = sda_sr[1];
  assign sda_q = sda_sr[2];

  logic scl_rise, scl_fall, start_c, stop_c, timeout;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign timeout  = (tcnt == TW'(TIMEOUT_CYC));

  logic [6:0] dev_addr;
  assign dev_addr = strap_en ? (BASE_ADDR | {5'd0, strap_sel}) : FIXED_ADDR;

  logic addr_hit;
  assign addr_hit = (sh[7:1] == dev_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sr <= 3'b111;
      sda_sr <= 3'b111;
    end else begin
      scl_sr <= {scl_sr[1:0], scl_in};
      sda_sr <= {sda_sr[1:0], sda_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          tcnt <= '0;
    else if (scl_s || state == S_IDLE || timeout) tcnt <= '0;
    else                                 tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      nxt       <= S_IDLE;
      bcnt      <= '0;
      sh        <= '0;
      txsh      <= '0;
      rs_ok     <= 1'b0;
      ara       <= 1'b0;
      sda_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      alert_clr <= 1'b0;
    end else begin
      reg_we    <= 1'b0;
      alert_clr <= 1'b0;
      if (timeout) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_c) begin
        rs_ok  <= (state == S_DATA) && (bcnt <= 4'd1);
        state  <= S_ADDR;
        bcnt   <= '0;
        ara    <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        if (state == S_STOPW && reg_defined) reg_we <= 1'b1;
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_REGA, S_DATA: begin
            if (scl_rise && bcnt < 4'd8) begin
              sh   <= {sh[6:0], sda_s};
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall && bcnt == 4'd8) begin
              bcnt <= '0;
              if (state == S_ADDR) begin
                if (addr_hit && !sh[0]) begin
                  sda_oe <= 1'b1; state <= S_ACK; nxt <= S_REGA;
                end else if (addr_hit && sh[0] && rs_ok) begin
                  sda_oe <= 1'b1; state <= S_ACK; nxt <= S_TX;
                  txsh   <= reg_defined ? reg_rdata : 8'h00;
                end else if (sh[7:1] == ALERT_ADDR && sh[0] && alert_pend && !rs_ok) begin
                  sda_oe <= 1'b1; state <= S_ACK; nxt <= S_TX;
                  txsh   <= {dev_addr, 1'b0};
                  ara    <= 1'b1;
                end else begin
                  state <= S_IGN;
                end
              end else if (state == S_REGA) begin
                reg_addr <= sh;
                sda_oe <= 1'b1; state <= S_ACK; nxt <= S_DATA;
              end else begin
                reg_wdata <= sh;
                sda_oe <= 1'b1; state <= S_ACK; nxt <= S_STOPW;
              end
            end
          end
          S_ACK: if (scl_fall) begin
            bcnt   <= '0;
            state  <= nxt;
            sda_oe <= (nxt == S_TX) ? ~txsh[7] : 1'b0;
          end
          S_STOPW: if (scl_fall) state <= S_IGN;
          S_TX: if (scl_fall) begin
            if (bcnt == 4'd7) begin
              sda_oe <= 1'b0;
              state  <= S_TXACK;
            end else begin
              bcnt   <= bcnt + 1'b1;
              txsh   <= {txsh[6:0], 1'b0};
              sda_oe <= ~txsh[6];
            end
          end
          S_TXACK: if (scl_rise) begin
            state     <= S_IGN;
            alert_clr <= ara;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_regslave_chk.sv
module smb_regslave_chk #(
  parameter int unsigned TIMEOUT_CYC = 750000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic reg_we,
  input logic alert_clr,
  input logic alert_pend
);
  int unsigned lowcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || scl_s)          lowcnt <= 0;
    else if (lowcnt != 32'hFFFF_FFFF) lowcnt <= lowcnt + 1;
  end

  a_r10_grab_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r2_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  a_r8_clr_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    alert_clr |-> alert_pend);

  a_r8_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    alert_clr |=> !alert_clr);

  a_r9_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
    (lowcnt > TIMEOUT_CYC + 4) |-> !sda_oe);
endmodule

bind smb_regslave smb_regslave_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .reg_we(reg_we), .alert_clr(alert_clr), .alert_pend(alert_pend)
);

// File: tb/smb_regslave_tb.sv
module smb_regslave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q  = 8;
  localparam int TO = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic strap_en = 1'b0;
  logic [1:0] strap_sel = 2'd0;
  logic alert_pend = 1'b0;
  logic sda_oe, reg_we, alert_clr, reg_defined, sda_line;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] rf [256];
  logic [7:0] expm [256];
  int total = 0, fails = 0, we_cnt = 0, clr_cnt = 0, grab_hi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line    = m_sda & ~sda_oe;
  assign reg_defined = (reg_addr < 8'h40);
  assign reg_rdata   = rf[reg_addr];

  smb_regslave #(.TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap_en(strap_en), .strap_sel(strap_sel), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .reg_defined(reg_defined), .alert_pend(alert_pend), .alert_clr(alert_clr)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 37 + 5);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) rf[i] <= init_val(i);
    end else if (reg_we) rf[reg_addr] <= reg_wdata;
  end

  logic sda_oe_d = 1'b0;
  always @(posedge clk) begin
    if (reg_we) we_cnt++;
    if (alert_clr) clr_cnt++;
    if (sda_oe && !sda_oe_d && m_scl) grab_hi++;
    sda_oe_d <= sda_oe;
  end

  function automatic logic [6:0] exp_dev(logic en, logic [1:0] sel);
    return en ? (7'h2C | {5'd0, sel}) : 7'h2E;
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] ra);
    return (ra < 8'h40) ? expm[ra] : 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; hq; m_scl = 1'b1; hq; m_sda = 1'b0; hq; m_scl = 1'b0; hq;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; hq; m_scl = 1'b1; hq; m_sda = 1'b1; hq;
  endtask

  task automatic wbit(logic b);
    m_sda = b; hq; m_scl = 1'b1; hq; hq; m_scl = 1'b0; hq;
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; hq; m_scl = 1'b1; hq; b = sda_line; hq; m_scl = 1'b0; hq;
  endtask

  task automatic sbyte(logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(x);
    ack = !x;
  endtask

  task automatic rbyte(logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(!mack);
  endtask

  task automatic wr_frame(logic [6:0] a, logic [7:0] ra, logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    a2 = 1'b0; a3 = 1'b0;
    bus_start;
    sbyte({a, 1'b0}, a1);
    if (a1) begin sbyte(ra, a2); sbyte(d, a3); end
    bus_stop;
    ok = a1 & a2 & a3;
  endtask

  task automatic rd_frame(logic [6:0] a, logic [7:0] ra, output logic ok, output logic [7:0] v);
    logic a1, a2, a3;
    a2 = 1'b0; a3 = 1'b0; v = 8'hFF;
    bus_start;
    sbyte({a, 1'b0}, a1);
    if (a1) begin
      sbyte(ra, a2);
      bus_start;
      sbyte({a, 1'b1}, a3);
      if (a3) rbyte(1'b0, v);
    end
    bus_stop;
    ok = a1 & a2 & a3;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual running expected done");
    summary;
    $finish;
  end

  initial begin
    logic ok, ack;
    logic [7:0] v, ra, d;
    logic [6:0] dev;
    int w0, c0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) expm[i] = init_val(i);
    repeat (4) @(negedge clk);
    chk("R11 sda_oe in reset", {31'd0, sda_oe}, 0);
    chk("R11 reg_we in reset", {31'd0, reg_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 outputs after reset", {29'd0, sda_oe, reg_we, alert_clr}, 0);

    // directed write and read, fixed address
    w0 = we_cnt;
    wr_frame(7'h2E, 8'h05, 8'hA5, ok);
    chk("R1 fixed address acked", {31'd0, ok}, 1);
    chk("R2 one strobe", we_cnt - w0, 1);
    expm[8'h05] = 8'hA5;
    rd_frame(7'h2E, 8'h05, ok, v);
    chk("R4 readback", {24'd0, v}, 8'hA5);

    // random traffic
    for (int n = 0; n < 22; n++) begin
      strap_en  = 1'($urandom);
      strap_sel = 2'($urandom);
      dev = exp_dev(strap_en, strap_sel);
      ra  = 8'($urandom_range(0, 8'h7F));
      d   = 8'($urandom);
      w0  = we_cnt;
      wr_frame(dev, ra, d, ok);
      chk("R1 write address acked", {31'd0, ok}, 1);
      chk((ra < 8'h40) ? "R2 strobe on defined" : "R6 no strobe on undefined",
          we_cnt - w0, (ra < 8'h40) ? 1 : 0);
      if (ra < 8'h40) expm[ra] = d;
      rd_frame(dev, ra, ok, v);
      chk("R4 read data", {23'd0, ok, v}, {23'd0, 1'b1, exp_read(ra)});
    end

    strap_en = 1'b1; strap_sel = 2'd1;
    dev = exp_dev(1'b1, 2'd1);

    // foreign address
    w0 = we_cnt;
    wr_frame(dev ^ 7'h10, 8'h03, 8'h11, ok);
    chk("R1 foreign address not acked", {31'd0, ok}, 0);
    chk("R1 foreign address no strobe", we_cnt - w0, 0);

    // general call
    bus_start; sbyte(8'h00, ack); bus_stop;
    chk("R7 general call not acked", {31'd0, ack}, 0);

    // missing stop
    w0 = we_cnt;
    bus_start; sbyte({dev, 1'b0}, ack); sbyte(8'h07, ack); sbyte(8'h3C, ack);
    chk("R3 data acked before restart", {31'd0, ack}, 1);
    bus_start; bus_stop;
    chk("R3 no strobe without stop", we_cnt - w0, 0);
    rd_frame(dev, 8'h07, ok, v);
    chk("R3 register unchanged", {24'd0, v}, {24'd0, exp_read(8'h07)});

    // extra byte
    w0 = we_cnt;
    bus_start; sbyte({dev, 1'b0}, ack); sbyte(8'h08, ack); sbyte(8'h5A, ack);
    sbyte(8'h66, ack); bus_stop;
    chk("R3 extra byte not acked", {31'd0, ack}, 0);
    chk("R3 no strobe with extra byte", we_cnt - w0, 0);
    rd_frame(dev, 8'h08, ok, v);
    chk("R3 register unchanged after extra", {24'd0, v}, {24'd0, exp_read(8'h08)});

    // read without index phase
    bus_start; sbyte({dev, 1'b1}, ack); bus_stop;
    chk("R5 bare read not acked", {31'd0, ack}, 0);

    // second byte of a read
    bus_start; sbyte({dev, 1'b0}, ack); sbyte(8'h09, ack);
    bus_start; sbyte({dev, 1'b1}, ack);
    rbyte(1'b1, v);
    chk("R4 first byte", {24'd0, v}, {24'd0, exp_read(8'h09)});
    rbyte(1'b0, v); bus_stop;
    chk("R5 second byte released", {24'd0, v}, 8'hFF);

    // undefined register write
    w0 = we_cnt;
    wr_frame(dev, 8'h90, 8'h77, ok);
    chk("R6 undefined write acked", {31'd0, ok}, 1);
    chk("R6 undefined write no strobe", we_cnt - w0, 0);
    rd_frame(dev, 8'h90, ok, v);
    chk("R4 undefined reads zero", {24'd0, v}, 8'h00);

    // alert response address
    bus_start; sbyte(8'h19, ack); bus_stop;
    chk("R8 no pending alert not acked", {31'd0, ack}, 0);
    alert_pend = 1'b1;
    c0 = clr_cnt;
    bus_start; sbyte(8'h19, ack);
    chk("R8 pending alert acked", {31'd0, ack}, 1);
    rbyte(1'b0, v); bus_stop;
    chk("R8 reply byte", {24'd0, v}, {24'd0, dev, 1'b0});
    chk("R8 clear pulse", clr_cnt - c0, 1);
    alert_pend = 1'b0;
    bus_start; sbyte(8'h19, ack); bus_stop;
    chk("R8 cleared alert not acked", {31'd0, ack}, 0);

    // timeout while slave holds ack
    bus_start;
    for (int i = 7; i >= 0; i--) wbit(dev[i > 0 ? i - 1 : 0] & (i > 0));
    m_sda = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 slave holding before timeout", {31'd0, sda_oe}, 1);
    repeat (TO + 20) @(negedge clk);
    chk("R9 released after timeout", {31'd0, sda_oe}, 0);
    m_scl = 1'b1; hq;
    wr_frame(dev, 8'h0A, 8'hC3, ok);
    chk("R9 served after timeout", {31'd0, ok}, 1);
    expm[8'h0A] = 8'hC3;
    rd_frame(dev, 8'h0A, ok, v);
    chk("R9 data after timeout", {24'd0, v}, 8'hC3);

    chk("R10 no grab while SCL high", grab_hi, 0);
    summary;
    $finish;
  end
endmodule